// File: doc/BRIEF.md
# Per-Bit Attribute Configuration Register Bank

This block holds a small set of 32-bit configuration registers. Every bit of every register has its own access behaviour, fixed at elaboration by a map in the package. A bit can be constant, plain read/write, set by hardware and cleared by writing one, set as a side effect of being read, kept through a warm reset, or frozen by a lock. Software reaches the bank over a simple strobe bus with a byte address, four byte enables, write data and registered read data. Hardware raises per-bit set events on a flat vector that holds one bit for each register bit.

The bank has two address regions. The low region covers byte offsets 0 to 255 and accepts any mix of byte enables, with byte lane k holding the byte at offset k, so data is little-endian. The extended region starts at offset 256 and takes only full-word accesses. One designated pointer register in the low region is also word-only. When a narrower access reaches a word-only register, the write is dropped, the read returns zero, and an error flag pulses.

There are two synchronous active-low resets. The cold reset returns every bit to its default. The warm reset returns the non-sticky bits to their defaults and leaves the sticky bits untouched.

Top module: `attr_regbank`

## Requirements
- R1: After a cold reset every bit holds its default. The defaults are: word 0x000 = 0x0000A500, word 0x00C = 0x00005A5A, and every other register = 0. rd_data and err are 0.
- R2: Read-only bits ignore every write. In the default map these are bits [15:8] of 0x000 (constant 0xA5) and bits [23:17] of 0x008 (constant 0).
- R3: Byte enable k selects wdata/rd_data bits [8k+7:8k], which is the byte at address offset k (little-endian). Read/write bits update only in the enabled lanes. Read/write bits are 0x000[7:0], the whole of 0x004, 0x00C[31:16] and the whole of 0x100.
- R4: Hardware-set bits become 1 in the cycle after hw_set is high for that bit. Writing 1 clears such a bit and writing 0 leaves it unchanged. hw_set bit index = register index × 32 + bit, where register indices 0..5 map to 0x000, 0x004, 0x008, 0x00C, 0x100, 0x104. These bits are 0x000[23:16], 0x104[15:0] and the sticky 0x008[7:0].
- R5: When hw_set and a write-1 clear reach the same bit in the same cycle, the bit ends up 1.
- R6: Read-set bits (0x000[31:24]) become 1 in the byte lanes enabled by a read. The read returns their value from before the set. A write of 1 clears them and a write of 0 has no effect.
- R7: Sticky bits (0x008[15:0] and 0x104[31:16]) keep their value during and after a warm reset. A warm reset returns all other bits to their defaults.
- R8: Lockable bits (0x00C[15:0] and 0x008[31:24]) ignore writes while lock_in is high or the lock bit 0x008[16] is 1.
- R9: Writing 1 to the lock bit 0x008[16] sets it. Writing 0 does not clear it. Only a warm or cold reset clears it.
- R10: Registers 0x004 and those from 0x100 upward take only accesses with be = 4'hF. A narrower write is dropped and a narrower read returns 0. In both cases err is 1 for exactly the following cycle.
- R11: rd_data is updated in the cycle after a read and holds until the next read. Lanes not enabled read as 0. An unmapped address reads 0 without an error. Address bits [1:0] are ignored.
- R12: When rd_en and wr_en are both high, the access is a write and has no read side effects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, synchronous, active low |
| cold_rst_n | input | 1 | Cold reset, synchronous, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address |
| be | input | 4 | Byte enables, lane k = address offset k |
| wdata | input | 32 | Write data |
| hw_set | input | 192 | Per-bit hardware set events |
| lock_in | input | 1 | External lock for lockable bits |
| rd_data | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse on a narrow access to a word-only register |

## Verification
A wrong bit state inside the bank can only be seen at the ports through a later read, so every stimulus is followed by a read of the register it touched. The corrupted value appears on rd_data one cycle after that read. Side effects that are easy to miss are tested this way: read-set bits changing in lanes that were not enabled, sticky bits lost across a warm reset, and a lock that leaks. A wrong lane mask or region decode shows as a mismatch in rd_data, or as a pulse on err, in the cycle after the offending access.

// File: rtl/attr_regbank_pkg.sv
// Package: access attribute codes and the default per-bit attribute and reset map.
// Assumes 32-bit registers; indices 0..3 are low-region words, 4.. extended.
package attr_regbank_pkg;

    typedef enum logic [2:0] {
        AT_RO     = 3'd0,   // constant, writes ignored
        AT_RW     = 3'd1,   // plain read/write
        AT_HSET   = 3'd2,   // hardware set, write-1 clear
        AT_RDSET  = 3'd3,   // set by read, write-1 clear
        AT_HSET_S = 3'd4,   // sticky hardware set, write-1 clear
        AT_RW_S   = 3'd5,   // sticky read/write
        AT_RW_L   = 3'd6,   // read/write unless locked
        AT_LOCK   = 3'd7    // write-1 set, cleared only by reset
    } attr_e;

    // Attribute of bit b of register r in the default map.
    function automatic attr_e bit_attr(input int r, input int b);
        attr_e a;
        a = AT_RW;
        case (r)
            0: begin
                if (b < 8)       a = AT_RW;
                else if (b < 16) a = AT_RO;
                else if (b < 24) a = AT_HSET;
                else             a = AT_RDSET;
            end
            2: begin
                if (b < 8)        a = AT_HSET_S;
                else if (b < 16)  a = AT_RW_S;
                else if (b == 16) a = AT_LOCK;
                else if (b < 24)  a = AT_RO;
                else              a = AT_RW_L;
            end
            3: a = (b < 16) ? AT_RW_L : AT_RW;
            5: a = (b < 16) ? AT_HSET : AT_RW_S;
            default: a = AT_RW;
        endcase
        return a;
    endfunction

    // Reset value of register r in the default map.
    function automatic logic [31:0] reg_default(input int r);
        logic [31:0] v;
        case (r)
            0:       v = 32'h0000_A500;
            3:       v = 32'h0000_5A5A;
            default: v = 32'h0000_0000;
        endcase
        return v;
    endfunction

    // True for attributes that survive a warm reset.
    function automatic logic is_sticky(input attr_e a);
        return (a == AT_RW_S) || (a == AT_HSET_S);
    endfunction

endpackage

// File: rtl/attr_regbank_decode.sv
// Address decode: turns a byte address into a one-hot register select and
// flags narrow accesses to word-only registers. Assumes LOW_SPAN is a power
// of two, PTR_IDX < NUM_LOW, and the extended region starts at LOW_SPAN.
module attr_regbank_decode #(
    parameter int AW       = 12,
    parameter int BE_W     = 4,
    parameter int NUM_LOW  = 4,
    parameter int NUM_EXT  = 2,
    parameter int PTR_IDX  = 1,
    parameter int LOW_SPAN = 256,
    localparam int NREG      = NUM_LOW + NUM_EXT,
    localparam int LOW_IDX_W = $clog2(LOW_SPAN / 4),
    localparam int EXT_IDX_W = AW - 2
) (
    input  logic [AW-1:0]   addr,
    input  logic [BE_W-1:0] be,
    input  logic            rd_en,
    input  logic            wr_en,
    output logic [NREG-1:0] sel,
    output logic            wr_go,
    output logic            rd_req,
    output logic            rd_go,
    output logic            viol
);

    logic                 in_low;
    logic [LOW_IDX_W-1:0] low_idx;
    logic [AW-1:0]        ext_off;
    logic [EXT_IDX_W-1:0] ext_idx;
    logic                 word_only;
    logic                 any_hit;
    logic                 unused_lsb;

    // Region split and per-region word index.
    always_comb begin
        in_low  = (addr < AW'(LOW_SPAN));
        low_idx = addr[LOW_IDX_W+1:2];
        ext_off = addr - AW'(LOW_SPAN);
        ext_idx = ext_off[AW-1:2];
    end

    assign unused_lsb = ^{addr[1:0], ext_off[1:0]};

    // One select line per register, low words first, then extended words.
    for (genvar r = 0; r < NREG; r++) begin : g_sel
        if (r < NUM_LOW) begin : g_low
            assign sel[r] = in_low && (low_idx == LOW_IDX_W'(r));
        end else begin : g_ext
            assign sel[r] = !in_low && (ext_idx == EXT_IDX_W'(r - NUM_LOW));
        end
    end

    // Legality of the access and the resulting read/write qualifiers.
    always_comb begin
        any_hit   = |sel;
        word_only = sel[PTR_IDX] || (!in_low && any_hit);
        viol      = (rd_en || wr_en) && word_only && !(&be);
        wr_go     = wr_en && any_hit && !viol;
        rd_req    = rd_en && !wr_en;
        rd_go     = rd_req && any_hit && !viol;
    end

endmodule

// File: rtl/attr_regbank_cell.sv
// One register bit whose update rule is chosen by the ATTR parameter.
// Assumes wr_hit and rd_hit are already qualified by select, lane and
// legality, and are never both high. Cold reset has priority over warm.
module attr_regbank_cell
    import attr_regbank_pkg::*;
#(
    parameter attr_e ATTR    = AT_RW,
    parameter logic  RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic rd_hit,
    input  logic hw_set,
    input  logic lock,
    output logic q
);

    localparam logic STICKY = is_sticky(ATTR);

    logic nxt;

    // Next value from the bit's own attribute rule.
    always_comb begin
        nxt = q;
        case (ATTR)
            AT_RW, AT_RW_S: if (wr_hit) nxt = wr_bit;
            AT_RW_L:        if (wr_hit && !lock) nxt = wr_bit;
            AT_HSET, AT_HSET_S: begin
                if (hw_set)               nxt = 1'b1;
                else if (wr_hit && wr_bit) nxt = 1'b0;
            end
            AT_RDSET: begin
                if (rd_hit)               nxt = 1'b1;
                else if (wr_hit && wr_bit) nxt = 1'b0;
            end
            AT_LOCK:        if (wr_hit && wr_bit) nxt = 1'b1;
            default:        nxt = q;
        endcase
    end

    // Two-level reset; sticky bits freeze while the warm reset is low.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            q <= RST_VAL;
        end else if (!rst_n) begin
            if (!STICKY) q <= RST_VAL;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/attr_regbank_rdmux.sv
// Read path: selects the addressed word, masks lanes that were not enabled,
// and registers the result. Assumes sel is one-hot or zero.
module attr_regbank_rdmux #(
    parameter int DW   = 32,
    parameter int NREG = 6,
    localparam int BE_W = DW / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cold_rst_n,
    input  logic               rd_req,
    input  logic               rd_go,
    input  logic [NREG-1:0]    sel,
    input  logic [BE_W-1:0]    be,
    input  logic [NREG*DW-1:0] regs,
    output logic [DW-1:0]      rd_data
);

    logic [DW-1:0] word;
    logic [DW-1:0] mask;

    // OR-reduce the selected register onto the read word.
    always_comb begin
        word = '0;
        for (int r = 0; r < NREG; r++) begin
            if (sel[r]) word = word | regs[r*DW +: DW];
        end
    end

    // Expand byte enables to a bit mask.
    for (genvar k = 0; k < BE_W; k++) begin : g_mask
        assign mask[8*k +: 8] = {8{be[k]}};
    end

    // Capture on every read request; illegal or unmapped reads give zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !cold_rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= rd_go ? (word & mask) : '0;
        end
    end

endmodule

// File: rtl/attr_regbank.sv
// Top: configuration register bank with per-bit access attributes.
// Builds one attribute cell per bit from the package map, derives the lock
// from lock_in and any lock-attribute bit, and pulses err on narrow accesses
// to word-only registers. Both resets are synchronous and active low.
module attr_regbank
    import attr_regbank_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int NUM_LOW  = 4,
    parameter int NUM_EXT  = 2,
    parameter int PTR_IDX  = 1,
    parameter int LOW_SPAN = 256,
    localparam int NREG  = NUM_LOW + NUM_EXT,
    localparam int BE_W  = DW / 8,
    localparam int NBITS = NREG * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [BE_W-1:0]  be,
    input  logic [DW-1:0]    wdata,
    input  logic [NBITS-1:0] hw_set,
    input  logic             lock_in,
    output logic [DW-1:0]    rd_data,
    output logic             err
);

    logic [NREG-1:0]  sel;
    logic             wr_go;
    logic             rd_req;
    logic             rd_go;
    logic             viol;
    logic [NBITS-1:0] regs_q;
    logic [NBITS-1:0] lock_vec;
    logic             lock_any;

    attr_regbank_decode #(
        .AW(AW), .BE_W(BE_W), .NUM_LOW(NUM_LOW), .NUM_EXT(NUM_EXT),
        .PTR_IDX(PTR_IDX), .LOW_SPAN(LOW_SPAN)
    ) u_decode (
        .addr(addr), .be(be), .rd_en(rd_en), .wr_en(wr_en),
        .sel(sel), .wr_go(wr_go), .rd_req(rd_req), .rd_go(rd_go), .viol(viol)
    );

    // Lock seen by lockable bits: external input or any lock-attribute bit.
    assign lock_any = lock_in || (|lock_vec);

    // One attribute cell per bit; attribute and default come from the package.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [DW-1:0] RV = reg_default(r);
        for (genvar b = 0; b < DW; b++) begin : g_bit
            localparam attr_e BA   = bit_attr(r, b);
            localparam int    LANE = b / 8;
            attr_regbank_cell #(.ATTR(BA), .RST_VAL(RV[b])) u_cell (
                .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
                .wr_hit(wr_go && sel[r] && be[LANE]),
                .wr_bit(wdata[b]),
                .rd_hit(rd_go && sel[r] && be[LANE]),
                .hw_set(hw_set[r*DW + b]),
                .lock(lock_any),
                .q(regs_q[r*DW + b])
            );
            assign lock_vec[r*DW + b] = (BA == AT_LOCK) ? regs_q[r*DW + b] : 1'b0;
        end
    end

    attr_regbank_rdmux #(.DW(DW), .NREG(NREG)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
        .rd_req(rd_req), .rd_go(rd_go), .sel(sel), .be(be),
        .regs(regs_q), .rd_data(rd_data)
    );

    // Error pulse for the cycle after a narrow access to a word-only register.
    always_ff @(posedge clk) begin
        if (!rst_n || !cold_rst_n) err <= 1'b0;
        else                       err <= viol;
    end

endmodule

// File: rtl/attr_regbank_sva.sv
// Checker for attr_regbank, bound to the top. Bit indices refer to the
// default map: register r bit b sits at regs_q[r*32+b].
module attr_regbank_sva #(
    parameter int NBITS = 192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cold_rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic [11:0]      addr,
    input logic [3:0]       be,
    input logic             hw_set16,
    input logic             lock_in,
    input logic             err,
    input logic [NBITS-1:0] regs_q
);

    logic unused_regs;
    assign unused_regs = ^regs_q;

    // R5: a hardware set leaves the bit at 1 whatever the write did.
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        hw_set16 |=> regs_q[16]);

    // R6: a read of word 0 with lane 3 enabled sets the read-set byte.
    a_r6_read_sets: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        (rd_en && !wr_en && addr == 12'h000 && be[3]) |=> (&regs_q[31:24]));

    // R7: sticky bits of word 0x008 do not move while a warm reset is applied.
    a_r7_sticky_warm: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !rst_n |=> (regs_q[79:64] == $past(regs_q[79:64])));

    // R8: lockable half of word 0x00C is frozen while locked.
    a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        (lock_in || regs_q[80]) |=> $stable(regs_q[111:96]));

    // R9: the lock bit stays set until a reset.
    a_r9_lock_holds: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        regs_q[80] |=> regs_q[80]);

    // R10: a narrow write to the pointer register leaves it unchanged.
    a_r10_narrow_drop: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        (wr_en && addr[11:2] == 10'd1 && be != 4'hF) |=> $stable(regs_q[63:32]));

    // R10: err only follows an access.
    a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n || !cold_rst_n)
        err |-> $past(rd_en || wr_en));

endmodule

bind attr_regbank attr_regbank_sva #(.NBITS(NBITS)) u_sva (
    .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be),
    .hw_set16(hw_set[16]), .lock_in(lock_in), .err(err), .regs_q(regs_q)
);

// File: tb/attr_regbank_test.sv
`timescale 1ns/1ps
module attr_regbank_test;

    localparam int NB = 192;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cold_rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic [NB-1:0] hw_set = '0;
    logic [NB-1:0] hw_next = '0;
    logic          lock_in = 1'b0;
    logic [31:0]   rd_data;
    logic          err;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic        is_rd;
        logic [31:0] data;
        logic        err;
        string       tag;
    } item_t;
    item_t sbq[$];
    logic  seen = 1'b0;

    always #2.5 clk = ~clk;

    attr_regbank uut (
        .clk(clk), .rst_n(rst_n), .cold_rst_n(cold_rst_n),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .be(be), .wdata(wdata),
        .hw_set(hw_set), .lock_in(lock_in), .rd_data(rd_data), .err(err)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one access per call, expectation pushed to the scoreboard.
    task automatic access(input logic is_wr, input logic [11:0] a, input logic [3:0] b,
                          input logic [31:0] d, input logic [31:0] exp,
                          input logic exp_err, input string tag);
        item_t it;
        @(negedge clk);
        it.is_rd = !is_wr; it.data = exp; it.err = exp_err; it.tag = tag;
        sbq.push_back(it);
        addr = a; be = b; wdata = d; wr_en = is_wr; rd_en = !is_wr;
        hw_set = hw_next;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; hw_set = '0; hw_next = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d,
                      input logic exp_err, input string tag);
        access(1'b1, a, b, d, 32'h0, exp_err, tag);
    endtask

    task automatic rd(input logic [11:0] a, input logic [3:0] b, input logic [31:0] exp,
                      input logic exp_err, input string tag);
        access(1'b0, a, b, 32'h0, exp, exp_err, tag);
    endtask

    task automatic hw_pulse(input logic [NB-1:0] v);
        @(negedge clk);
        hw_set = v;
        @(posedge clk);
        #1 hw_set = '0;
    endtask

    task automatic pulse_reset(input logic cold);
        @(negedge clk);
        rst_n = 1'b0;
        if (cold) cold_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cold_rst_n = 1'b1;
    endtask

    // Monitor: compare outputs half a cycle after each access edge.
    always @(posedge clk) seen <= rd_en || wr_en;

    always @(negedge clk) begin
        if (seen) begin
            if (sbq.size() == 0) begin
                check(1'b0, "SB", "unexpected result", 32'h0, 32'h0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                if (it.is_rd) check(rd_data === it.data, it.tag, "rd_data", rd_data, it.data);
                check(err === it.err, it.tag, "err", {31'h0, err}, {31'h0, it.err});
            end
        end
    end

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1; cold_rst_n = 1'b1;
        @(negedge clk);
        check(rd_data === 32'h0, "R1", "rd_data after reset", rd_data, 32'h0);
        check(err === 1'b0, "R1", "err after reset", {31'h0, err}, 32'h0);

        // R1 defaults; R6 first read returns pre-set value
        rd(12'h000, 4'hF, 32'h0000_A500, 1'b0, "R1");
        rd(12'h00C, 4'hF, 32'h0000_5A5A, 1'b0, "R1");
        rd(12'h000, 4'hF, 32'hFF00_A500, 1'b0, "R6");

        // R2 read-only byte ignores writes; R6 write 0 keeps read-set byte
        wr(12'h000, 4'hF, 32'h00FF_5A3C, 1'b0, "R2");
        rd(12'h000, 4'hF, 32'hFF00_A53C, 1'b0, "R2");

        // R6 lane-selective read set
        wr(12'h000, 4'b1000, 32'h0F00_0000, 1'b0, "R6");
        rd(12'h000, 4'b0111, 32'h0000_A53C, 1'b0, "R6");
        rd(12'h000, 4'b1000, 32'hF000_0000, 1'b0, "R6");
        rd(12'h000, 4'b1000, 32'hFF00_0000, 1'b0, "R6");

        // R4 hardware set and write-1 clear
        hw_pulse(NB'(1) << 16 | NB'(1) << 23);
        rd(12'h000, 4'b0100, 32'h0081_0000, 1'b0, "R4");
        wr(12'h000, 4'b0100, 32'h0000_0000, 1'b0, "R4");
        rd(12'h000, 4'b0100, 32'h0081_0000, 1'b0, "R4");
        wr(12'h000, 4'b0100, 32'h0001_0000, 1'b0, "R4");
        rd(12'h000, 4'b0100, 32'h0080_0000, 1'b0, "R4");

        // R5 set wins over same-cycle clear
        hw_next = NB'(1) << 23;
        wr(12'h000, 4'b0100, 32'h0080_0000, 1'b0, "R5");
        rd(12'h000, 4'b0100, 32'h0080_0000, 1'b0, "R5");
        wr(12'h000, 4'b0100, 32'h0080_0000, 1'b0, "R4");
        rd(12'h000, 4'b0100, 32'h0000_0000, 1'b0, "R4");

        // R3 little-endian lanes; R11 lane masking on read
        wr(12'h00C, 4'b0010, 32'h0000_7700, 1'b0, "R3");
        rd(12'h00C, 4'hF, 32'h0000_775A, 1'b0, "R3");
        wr(12'h00E, 4'b1100, 32'hBEEF_0000, 1'b0, "R3");
        rd(12'h00C, 4'hF, 32'hBEEF_775A, 1'b0, "R3");
        rd(12'h00C, 4'b0110, 32'h00EF_7700, 1'b0, "R11");

        // R10 word-only pointer register
        wr(12'h004, 4'hF, 32'h1234_5678, 1'b0, "R10");
        wr(12'h004, 4'b0011, 32'h0000_FFFF, 1'b1, "R10");
        rd(12'h004, 4'b0011, 32'h0000_0000, 1'b1, "R10");
        rd(12'h004, 4'hF, 32'h1234_5678, 1'b0, "R10");

        // R10 extended region
        wr(12'h100, 4'hF, 32'hCAFE_F00D, 1'b0, "R10");
        wr(12'h100, 4'b0001, 32'h0000_00FF, 1'b1, "R10");
        rd(12'h100, 4'b0001, 32'h0000_0000, 1'b1, "R10");
        rd(12'h100, 4'hF, 32'hCAFE_F00D, 1'b0, "R10");

        // R11 unmapped addresses
        rd(12'h040, 4'hF, 32'h0000_0000, 1'b0, "R11");
        rd(12'h108, 4'hF, 32'h0000_0000, 1'b0, "R11");

        // R12 simultaneous strobes act as a write: no read-set side effect
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 12'h000; be = 4'b1000; wdata = 32'hFF00_0000;
        @(posedge clk);
        #1 wr_en = 1'b0; rd_en = 1'b0;
        sbq.push_back('{1'b0, 32'h0, 1'b0, "R12"});
        rd(12'h000, 4'b1000, 32'h0000_0000, 1'b0, "R12");

        // R8 external lock
        wr(12'h00C, 4'hF, 32'h1111_2222, 1'b0, "R8");
        rd(12'h00C, 4'hF, 32'h1111_2222, 1'b0, "R8");
        @(negedge clk) lock_in = 1'b1;
        wr(12'h00C, 4'hF, 32'h3333_4444, 1'b0, "R8");
        rd(12'h00C, 4'hF, 32'h3333_2222, 1'b0, "R8");
        @(negedge clk) lock_in = 1'b0;
        wr(12'h00C, 4'hF, 32'h5555_6666, 1'b0, "R8");
        rd(12'h00C, 4'hF, 32'h5555_6666, 1'b0, "R8");

        // R9 lock bit: set by 1, not cleared by 0
        wr(12'h008, 4'b0100, 32'h0001_0000, 1'b0, "R9");
        wr(12'h00C, 4'hF, 32'h7777_8888, 1'b0, "R9");
        rd(12'h00C, 4'hF, 32'h7777_6666, 1'b0, "R9");
        wr(12'h008, 4'b0100, 32'h0000_0000, 1'b0, "R9");
        wr(12'h008, 4'b1000, 32'hC300_0000, 1'b0, "R8");
        rd(12'h008, 4'hF, 32'h0001_0000, 1'b0, "R9");

        // R7 sticky fields before a warm reset
        wr(12'h008, 4'b0010, 32'h0000_AB00, 1'b0, "R7");
        hw_pulse(NB'(4'hF) << 64);
        wr(12'h104, 4'hF, 32'h9999_0000, 1'b0, "R7");
        hw_pulse(NB'(1) << 160);
        rd(12'h008, 4'hF, 32'h0001_AB0F, 1'b0, "R7");
        rd(12'h104, 4'hF, 32'h9999_0001, 1'b0, "R7");

        pulse_reset(1'b0);
        rd(12'h008, 4'hF, 32'h0000_AB0F, 1'b0, "R7");
        rd(12'h104, 4'hF, 32'h9999_0000, 1'b0, "R7");
        rd(12'h00C, 4'hF, 32'h0000_5A5A, 1'b0, "R7");
        rd(12'h000, 4'hF, 32'h0000_A500, 1'b0, "R7");
        rd(12'h004, 4'hF, 32'h0000_0000, 1'b0, "R7");
        wr(12'h008, 4'b1000, 32'hC300_0000, 1'b0, "R9");
        rd(12'h008, 4'hF, 32'hC300_AB0F, 1'b0, "R9");

        // R1 cold reset clears sticky fields too
        pulse_reset(1'b1);
        rd(12'h008, 4'hF, 32'h0000_0000, 1'b0, "R1");
        rd(12'h104, 4'hF, 32'h0000_0000, 1'b0, "R1");
        rd(12'h000, 4'hF, 32'h0000_A500, 1'b0, "R1");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "SB", "pending items", sbq.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule